// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a 32-bit processor that retires one instruction on every rising clock edge. It covers a small integer subset: five register-to-register operations (add, subtract, and, or, signed set-less-than), add-immediate, word load, word store, branch-if-equal and an absolute jump. The instruction is decoded by purely combinational control. Register operands are read, the ALU result and memory data are formed, and the next program counter is chosen, all within the same cycle. The program counter, the register file and the data memory then update together on the next edge.

Instruction storage and data storage are small word arrays inside the core. Both read combinationally. Instruction words are written through a program-load port while the core is held in reset. Each executed cycle shows its effect on observation outputs: the register write that commits at the coming edge and the data-memory write that commits at the same edge. An environment can follow execution from these outputs alone.

Top module: `occ_core`

## Requirements
- R1: While `rst_n` is low the program counter reads 0 and neither a register write nor a data-memory write is signalled. The first instruction executed after release is the word at byte address 0.
- R2: Every instruction other than a taken branch or a jump advances the program counter by 4 on the next edge. This includes unsupported encodings.
- R3: With opcode bits 31:26 = 0x00 and shift field bits 10:6 = 0, the function field bits 5:0 selects the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed less-than giving 1 or 0. The operands are registers rs (bits 25:21) and rt (bits 20:16). The result is written to rd (bits 15:11).
- R4: Opcode 0x08 writes rs plus the sign-extended 16-bit immediate (bits 15:0) to rt.
- R5: Opcode 0x23 writes to rt the data word at byte address rs + sign-extended immediate. Opcode 0x2B writes rt to that data word and signals no register write.
- R6: Opcode 0x04 compares rs and rt and writes nothing. If they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2. Otherwise it is PC+4.
- R7: Opcode 0x02 writes nothing. The next PC is bits 31:28 of PC+4, followed by the 26-bit field in bits 25:0, followed by two zero bits.
- R8: Register 0 always reads as zero. A write aimed at it is signalled but does not change its value.
- R9: Any other opcode, a type-0 word with a non-zero shift field, or a type-0 word with any other function code executes as a no-op: no register write and no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state commits on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| prog_we | input | 1 | Instruction-word write enable, used during reset |
| prog_addr | input | IMEM_AW | Word index of the instruction word written |
| prog_wdata | input | 32 | Instruction word to store |
| pc_o | output | 32 | Current program counter |
| wb_en_o | output | 1 | Register write committed at the coming edge |
| wb_reg_o | output | 5 | Destination register number of that write |
| wb_data_o | output | 32 | Data of that write |
| dm_we_o | output | 1 | Data-memory write committed at the coming edge |
| dm_addr_o | output | 32 | Byte address of the data access (ALU result) |
| dm_wdata_o | output | 32 | Data stored by that write |

## Verification
The assertions assume that `rst_n` rises away from the clock edge and that the instruction array is not written while the core runs. The stimulus meets both: the bench loads the whole program, including zero words that decode as no-ops, only while reset is held, and it releases reset on a falling edge. The bench never reads a register or a data word that the program has not written. This keeps every compared value defined even though the register file and data memory have no reset. The program covers every supported operation, both branch outcomes, a jump, writes aimed at register 0 and three kinds of unsupported encoding.

// File: rtl/occ_pkg.sv
package occ_pkg;

  localparam int unsigned XLEN    = 32;
  localparam int unsigned NREGS   = 32;
  localparam int unsigned RIDX_W  = $clog2(NREGS);

  localparam logic [5:0] OPC_REG  = 6'h00;
  localparam logic [5:0] OPC_LDW  = 6'h23;
  localparam logic [5:0] OPC_STW  = 6'h2B;
  localparam logic [5:0] OPC_BEQ  = 6'h04;
  localparam logic [5:0] OPC_ADDI = 6'h08;
  localparam logic [5:0] OPC_JMP  = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT
  } alu_fn_e;

  typedef struct packed {
    logic    rf_we;
    logic    dst_is_rd;
    logic    b_is_imm;
    logic    wb_from_mem;
    logic    mem_we;
    logic    is_beq;
    logic    is_jmp;
    alu_fn_e alu_fn;
  } ctl_t;

endpackage

// File: rtl/occ_decode.sv
module occ_decode
  import occ_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [4:0] shamt,
  input  logic [5:0] funct,
  output ctl_t       ctl
);

  always_comb begin
    ctl = '{rf_we: 1'b0, dst_is_rd: 1'b0, b_is_imm: 1'b0, wb_from_mem: 1'b0,
            mem_we: 1'b0, is_beq: 1'b0, is_jmp: 1'b0, alu_fn: ALU_ADD};
    unique case (opcode)
      OPC_REG: begin
        if (shamt == 5'd0) begin
          ctl.dst_is_rd = 1'b1;
          ctl.rf_we     = 1'b1;
          unique case (funct)
            FN_ADD:  ctl.alu_fn = ALU_ADD;
            FN_SUB:  ctl.alu_fn = ALU_SUB;
            FN_AND:  ctl.alu_fn = ALU_AND;
            FN_OR:   ctl.alu_fn = ALU_OR;
            FN_SLT:  ctl.alu_fn = ALU_SLT;
            default: ctl.rf_we  = 1'b0;
          endcase
        end
      end
      OPC_ADDI: begin
        ctl.rf_we    = 1'b1;
        ctl.b_is_imm = 1'b1;
      end
      OPC_LDW: begin
        ctl.rf_we       = 1'b1;
        ctl.b_is_imm    = 1'b1;
        ctl.wb_from_mem = 1'b1;
      end
      OPC_STW: begin
        ctl.b_is_imm = 1'b1;
        ctl.mem_we   = 1'b1;
      end
      OPC_BEQ: begin
        ctl.is_beq = 1'b1;
        ctl.alu_fn = ALU_SUB;
      end
      OPC_JMP: ctl.is_jmp = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/occ_regfile.sv
module occ_regfile #(
  parameter int unsigned DW    = 32,
  parameter int unsigned NREG  = 32,
  localparam int unsigned AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [DW-1:0] rd1,
  output logic [DW-1:0] rd2
);

  logic [DW-1:0] bank [NREG];
  logic          wr_hit;

  // entry 0 is never written; reads of index 0 are forced to zero
  assign wr_hit = we && (wa != '0);

  always_ff @(posedge clk) begin
    if (wr_hit) begin
      bank[wa] <= wd;
    end
  end

  always_comb begin
    rd1 = (ra1 == '0) ? '0 : bank[ra1];
    rd2 = (ra2 == '0) ? '0 : bank[ra2];
  end

endmodule

// File: rtl/occ_alu.sv
module occ_alu
  import occ_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  alu_fn_e       fn,
  output logic [DW-1:0] y,
  output logic          zero
);

  always_comb begin
    unique case (fn)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(DW-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/occ_core.sv
module occ_core
  import occ_pkg::*;
#(
  parameter int unsigned IMEM_AW = 6,
  parameter int unsigned DMEM_AW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_we,
  input  logic [IMEM_AW-1:0] prog_addr,
  input  logic [XLEN-1:0]    prog_wdata,
  output logic [XLEN-1:0]    pc_o,
  output logic               wb_en_o,
  output logic [RIDX_W-1:0]  wb_reg_o,
  output logic [XLEN-1:0]    wb_data_o,
  output logic               dm_we_o,
  output logic [XLEN-1:0]    dm_addr_o,
  output logic [XLEN-1:0]    dm_wdata_o
);

  localparam int unsigned IMEM_WORDS = 1 << IMEM_AW;
  localparam int unsigned DMEM_WORDS = 1 << DMEM_AW;

  logic [XLEN-1:0]   imem [IMEM_WORDS];
  logic [XLEN-1:0]   dmem [DMEM_WORDS];

  logic [XLEN-1:0]   pc_q, pc_d, pc_plus4, br_tgt, jmp_tgt;
  logic [XLEN-1:0]   instr, imm_sx, rs_val, rt_val, alu_b, alu_y, mem_rd;
  logic              alu_zero, run, rf_we, mem_we;
  logic [RIDX_W-1:0] dst_idx;
  ctl_t              ctl;

  // instruction store: loaded through the program port
  always_ff @(posedge clk) begin
    if (prog_we) begin
      imem[prog_addr] <= prog_wdata;
    end
  end

  assign instr  = imem[pc_q[IMEM_AW+1:2]];
  assign imm_sx = {{(XLEN-16){instr[15]}}, instr[15:0]};

  occ_decode u_dec (
    .opcode (instr[31:26]),
    .shamt  (instr[10:6]),
    .funct  (instr[5:0]),
    .ctl    (ctl)
  );

  assign run     = rst_n;
  assign rf_we   = ctl.rf_we & run;
  assign mem_we  = ctl.mem_we & run;
  assign dst_idx = ctl.dst_is_rd ? instr[15:11] : instr[20:16];

  occ_regfile #(.DW(XLEN), .NREG(NREGS)) u_rf (
    .clk (clk),
    .we  (rf_we),
    .wa  (dst_idx),
    .wd  (wb_data_o),
    .ra1 (instr[25:21]),
    .ra2 (instr[20:16]),
    .rd1 (rs_val),
    .rd2 (rt_val)
  );

  assign alu_b = ctl.b_is_imm ? imm_sx : rt_val;

  occ_alu #(.DW(XLEN)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .fn   (ctl.alu_fn),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data store: combinational read, write enabled by store decode
  assign mem_rd = dmem[alu_y[DMEM_AW+1:2]];

  always_ff @(posedge clk) begin
    if (mem_we) begin
      dmem[alu_y[DMEM_AW+1:2]] <= rt_val;
    end
  end

  // next-PC selection
  assign pc_plus4 = pc_q + XLEN'(4);
  assign br_tgt   = pc_plus4 + (imm_sx << 2);
  assign jmp_tgt  = {pc_plus4[XLEN-1:28], instr[25:0], 2'b00};

  always_comb begin
    pc_d = pc_plus4;
    if (ctl.is_jmp) begin
      pc_d = jmp_tgt;
    end else if (ctl.is_beq && alu_zero) begin
      pc_d = br_tgt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_d;
    end
  end

  assign pc_o       = pc_q;
  assign wb_en_o    = rf_we;
  assign wb_reg_o   = dst_idx;
  assign wb_data_o  = ctl.wb_from_mem ? mem_rd : alu_y;
  assign dm_we_o    = mem_we;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rt_val;

endmodule

// File: rtl/occ_core_chk.sv
module occ_core_chk
  import occ_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [XLEN-1:0]   pc,
  input logic [XLEN-1:0]   instr,
  input logic              alu_zero,
  input logic              wb_en,
  input logic              dm_we,
  input logic [RIDX_W-1:0] ra1,
  input logic [XLEN-1:0]   rd1
);

  logic [5:0]      op;
  logic [XLEN-1:0] seq_pc;

  assign op     = instr[31:26];
  assign seq_pc = pc + 32'd4;

  // R1: quiet and at address zero while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (pc == '0 && !wb_en && !dm_we);
    end
  end

  // R2: non-control instructions step by one word
  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OPC_BEQ && op != OPC_JMP) |=> pc == $past(seq_pc));

  // R5: a store never writes a register
  a_r5_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    dm_we |-> !wb_en);

  // R6: taken branch lands on the offset target
  a_r6_beq_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OPC_BEQ && alu_zero) |=>
      pc == $past(seq_pc) + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});

  // R6: untaken branch falls through
  a_r6_beq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OPC_BEQ && !alu_zero) |=> pc == $past(seq_pc));

  // R7: jump target assembled from region bits and the 26-bit field
  a_r7_jump_tgt: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OPC_JMP) |=> pc == {$past(seq_pc[31:28]), $past(instr[25:0]), 2'b00});

  // R7: jump and branch write nothing
  a_r7_ctrl_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OPC_JMP || op == OPC_BEQ) |-> (!wb_en && !dm_we));

  // R8: register zero reads as zero
  a_r8_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (ra1 == '0) |-> rd1 == '0);

endmodule

bind occ_core occ_core_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pc       (pc_o),
  .instr    (instr),
  .alu_zero (alu_zero),
  .wb_en    (wb_en_o),
  .dm_we    (dm_we_o),
  .ra1      (instr[25:21]),
  .rd1      (rs_val)
);

// File: tb/occ_core_tb.sv
`timescale 1ns/1ps
module occ_core_tb;

  localparam int IAW = 6;
  localparam int NWORDS = 1 << IAW;
  localparam int RUN_CYCLES = 40;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           prog_we;
  logic [IAW-1:0] prog_addr;
  logic [31:0]    prog_wdata;
  logic [31:0]    pc_o, wb_data_o, dm_addr_o, dm_wdata_o;
  logic           wb_en_o, dm_we_o;
  logic [4:0]     wb_reg_o;

  always #2.5 clk = ~clk;

  occ_core #(.IMEM_AW(IAW), .DMEM_AW(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_wdata(prog_wdata), .pc_o(pc_o), .wb_en_o(wb_en_o), .wb_reg_o(wb_reg_o),
    .wb_data_o(wb_data_o), .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o),
    .dm_wdata_o(dm_wdata_o)
  );

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  logic [31:0] prog [NWORDS];
  logic [31:0] m_reg [32];
  logic [31:0] m_mem [64];
  logic [31:0] m_pc;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [31:0] rdreg(logic [4:0] i);
    return (i == 0) ? 32'h0 : m_reg[i];
  endfunction

  task automatic build_program();
    for (int i = 0; i < NWORDS; i++) prog[i] = 32'h0;
    prog[0]  = enc_i(6'h08, 0, 1, 5);
    prog[1]  = enc_i(6'h08, 0, 2, -3);
    prog[2]  = enc_r(1, 2, 3, 0, 6'h20);
    prog[3]  = enc_r(1, 2, 4, 0, 6'h22);
    prog[4]  = enc_r(1, 2, 5, 0, 6'h24);
    prog[5]  = enc_r(1, 2, 6, 0, 6'h25);
    prog[6]  = enc_r(2, 1, 7, 0, 6'h2A);
    prog[7]  = enc_r(1, 2, 8, 0, 6'h2A);
    prog[8]  = enc_i(6'h2B, 0, 4, 8);
    prog[9]  = enc_i(6'h23, 0, 9, 8);
    prog[10] = enc_i(6'h08, 0, 0, 7);
    prog[11] = enc_r(0, 0, 10, 0, 6'h20);
    prog[12] = enc_r(1, 2, 13, 0, 6'h27);
    prog[13] = {6'h3F, 26'h12345};
    prog[14] = enc_r(1, 2, 13, 3, 6'h20);
    prog[15] = enc_i(6'h04, 1, 2, 5);
    prog[16] = enc_i(6'h04, 9, 4, 2);
    prog[17] = enc_i(6'h08, 0, 11, 99);
    prog[18] = enc_i(6'h08, 0, 11, 98);
    prog[19] = {6'h02, 26'd22};
    prog[20] = enc_i(6'h08, 0, 11, 97);
    prog[21] = enc_i(6'h08, 0, 11, 96);
    prog[22] = enc_i(6'h2B, 9, 6, -4);
    prog[23] = enc_i(6'h23, 0, 12, 4);
    prog[24] = enc_r(2, 1, 14, 0, 6'h22);
    prog[25] = enc_i(6'h04, 0, 0, -1);
  endtask

  // one reference step: compare current outputs, then advance model state
  task automatic ref_step(inout string pc_tag);
    logic [31:0] ins, a, b, sx, npc, res;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd, sh;
    bit          e_we, e_dwe, legal;
    logic [4:0]  e_reg;
    logic [31:0] e_data;
    string       tag;
    ins = prog[m_pc[IAW+1:2]];
    op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    sh = ins[10:6];  fn = ins[5:0];
    a = rdreg(rs); b = rdreg(rt);
    sx = {{16{ins[15]}}, ins[15:0]};
    npc = m_pc + 4; e_we = 0; e_dwe = 0; e_reg = 0; e_data = 0; tag = "R9";
    case (op)
      6'h00: begin
        legal = (sh == 0);
        res = 0;
        case (fn)
          6'h20: res = a + b;
          6'h22: res = a - b;
          6'h24: res = a & b;
          6'h25: res = a | b;
          6'h2A: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: legal = 0;
        endcase
        if (legal) begin
          e_we = 1; e_reg = rd; e_data = res;
          tag = (rs == 0 && rt == 0) ? "R8" : "R3";
        end
      end
      6'h08: begin
        e_we = 1; e_reg = rt; e_data = a + sx;
        tag = (rt == 0) ? "R8" : "R4";
      end
      6'h23: begin e_we = 1; e_reg = rt; e_data = m_mem[(a + sx) >> 2]; tag = "R5"; end
      6'h2B: begin e_dwe = 1; tag = "R5"; end
      6'h04: begin if (a == b) npc = m_pc + 4 + (sx << 2); tag = "R6"; end
      6'h02: begin npc = {m_pc[31:28] + 4'(((m_pc + 4) >> 28) != m_pc[31:28]), ins[25:0], 2'b00};
                   npc[31:28] = (m_pc + 32'd4) >> 28; tag = "R7"; end
      default: tag = "R9";
    endcase
    check({pc_tag, " pc (R2)"}, pc_o, m_pc);
    check({tag, " wb_en"}, {31'b0, wb_en_o}, {31'b0, e_we});
    check({tag, " dm_we"}, {31'b0, dm_we_o}, {31'b0, e_dwe});
    if (e_we) begin
      check({tag, " wb_reg"}, {27'b0, wb_reg_o}, {27'b0, e_reg});
      check({tag, " wb_data"}, wb_data_o, e_data);
    end
    if (e_dwe) begin
      check({tag, " dm_addr"}, dm_addr_o, a + sx);
      check({tag, " dm_wdata"}, dm_wdata_o, b);
    end
    if (e_we && e_reg != 0) m_reg[e_reg] = e_data;
    if (e_dwe) m_mem[(a + sx) >> 2] = b;
    m_pc = npc;
    pc_tag = tag;
  endtask

  initial begin
    string pt;
    rst_n = 1'b1; prog_we = 1'b0; prog_addr = '0; prog_wdata = '0;
    #1 rst_n = 1'b0;
    build_program();
    for (int i = 0; i < NWORDS; i++) begin
      @(negedge clk);
      prog_we = 1'b1; prog_addr = IAW'(i); prog_wdata = prog[i];
      if (i % 16 == 3) begin
        check("R1 reset pc", pc_o, 32'h0);
        check("R1 reset wb_en", {31'b0, wb_en_o}, 32'h0);
        check("R1 reset dm_we", {31'b0, dm_we_o}, 32'h0);
      end
    end
    @(negedge clk);
    prog_we = 1'b0;
    m_pc = 32'h0;
    for (int i = 0; i < 32; i++) m_reg[i] = 32'h0;
    for (int i = 0; i < 64; i++) m_mem[i] = 32'h0;
    check("R1 reset pc before release", pc_o, 32'h0);
    rst_n = 1'b1;
    pt = "R1";
    for (int c = 0; c < RUN_CYCLES; c++) begin
      #0.5;
      ref_step(pt);
      @(negedge clk);
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule